// File: doc/BRIEF.md
# Three-Phase Line-Cycle Energy Accumulator

This block forms, for every valid sample, a total apparent power term from the RMS voltage and RMS current of three phases. It also forms signed active and reactive power sums. It accumulates these terms over a programmed number of half line cycles. A half-cycle tick from an upstream zero-crossing detector marks each half cycle. When the programmed count of ticks has been seen, the block latches the accumulated totals into two readable energy registers, pulses an update flag, and restarts accumulation from zero.

A two-bit wiring-mode field decides how the phase-B apparent term is built:

- its own voltage,
- the floor average of the phase-A and phase-C voltages, or
- the phase-A voltage.

Per-phase select bits include or drop each phase's term. A swap control redirects the two registers. With swap set, the signed register receives reactive power. The unsigned register receives the summed magnitude of active power. In this case both use the power phase-select bits. The apparent term keeps the same LSB weight as a free-running apparent accumulation: one count of V·I per sample.

Top module: `lc_energy_acc`

## Requirements
- R1: After reset, line_act_o, line_va_o and upd_o are all zero.
- R2: With swap_en_i low and wire_mode_i = 0, each valid sample adds VA·IA + VB·IB + VC·IC to the value later shown on line_va_o. Phase index 0 is A, 1 is B and 2 is C in every per-phase bus.
- R3: With wire_mode_i = 1, the phase-B apparent term is floor((VA + VC) / 2) · IB.
- R4: With wire_mode_i = 2, the phase-B apparent term is VA · IB.
- R5: wire_mode_i = 3 gives exactly the mode-0 result.
- R6: Bit k of va_sel_i enables phase k's apparent term; a cleared bit removes that term.
- R7: Windows are closed by ticks.
  - Each valid sample is added into the running totals.
  - On the tick that completes hc_count_i ticks, the registers take the window total, including a valid sample in that same cycle.
  - upd_o is high for exactly the cycle after that tick.
  - The next window starts from zero.
  - The registers hold their value in all other cycles.
- R8: With swap_en_i low, line_act_o receives the two's-complement sum of the signed active samples p_i of the phases enabled in pq_sel_i.
- R9: With swap_en_i high, line_act_o receives the signed sum of the reactive samples q_i, and line_va_o receives the sum of |p_i|. Both use pq_sel_i, and wire_mode_i and va_sel_i have no effect.
- R10: With hc_count_i = 0, the running totals and tick count are held cleared, no update occurs, and the registers keep their values.
- R11: Sample inputs present while smp_vld_i is low do not contribute to any total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld_i | input | 1 | Sample inputs valid this cycle |
| hc_tick_i | input | 1 | Half line cycle tick |
| wire_mode_i | input | 2 | Phase-B apparent term mode (0..3) |
| va_sel_i | input | 3 | Apparent term phase enables, bit0 = A |
| pq_sel_i | input | 3 | Active/reactive phase enables, bit0 = A |
| swap_en_i | input | 1 | Redirect reactive / unsigned active |
| hc_count_i | input | CNT_W (6) | Half cycles per window, 0 suspends |
| v_rms_i | input | 3×RMS_W (24) | Unsigned RMS voltages, element 0 = A |
| i_rms_i | input | 3×RMS_W (24) | Unsigned RMS currents, element 0 = A |
| p_i | input | 3×PWR_W (36) | Signed active power samples |
| q_i | input | 3×PWR_W (36) | Signed reactive power samples |
| line_act_o | output | ACC_W (32) | Signed line-cycle active/reactive energy |
| line_va_o | output | ACC_W (32) | Unsigned line-cycle apparent/active energy |
| upd_o | output | 1 | One-cycle pulse when registers reload |

## Verification
The closing of a window and the arrival of a new valid sample can happen in the same clock cycle. The block must then add that sample to the window being latched, and not carry it into the fresh window. The bench forces this collision on nearly every closing tick. It also closes some windows with a tick that has no sample. A scoreboard model holds expected window totals, built from the requirement formulas. Each update pulse is compared against that model, so a sample that lands in the wrong window shows up as a mismatch in two consecutive results.

// File: rtl/ae_pkg.sv
// Package: shared encodings for the line-cycle energy accumulator.
// Assumes phase index 0 = A, 1 = B, 2 = C on every per-phase bus.
package ae_pkg;
    localparam int PH_A = 0;
    localparam int PH_B = 1;
    localparam int PH_C = 2;
    localparam int N_PH = 3;

    // Phase-B apparent term construction
    typedef enum logic [1:0] {
        WM_PLAIN   = 2'd0,
        WM_AVG_B   = 2'd1,
        WM_SHARE_A = 2'd2,
        WM_RSVD    = 2'd3
    } wire_mode_e;
endpackage

// File: rtl/ae_va_sum.sv
// Module: per-sample total apparent power term.
// Builds the phase voltages per wiring mode, multiplies by the RMS currents
// and sums the enabled phases. Purely combinational; reserved mode = plain.
module ae_va_sum
    import ae_pkg::*;
#(
    parameter int RMS_W = 8,
    localparam int PROD_W = 2 * RMS_W,
    localparam int SUM_W  = PROD_W + 2
) (
    input  logic [1:0]                  mode_i,
    input  logic [N_PH-1:0]             sel_i,
    input  logic [N_PH-1:0][RMS_W-1:0]  v_i,
    input  logic [N_PH-1:0][RMS_W-1:0]  i_i,
    output logic [SUM_W-1:0]            sum_o
);
    logic [RMS_W:0]    avg_ac;
    logic [RMS_W-1:0]  vb_eff;
    logic [RMS_W-1:0]  v_eff [N_PH];
    logic [PROD_W-1:0] prod  [N_PH];

    assign avg_ac = {1'b0, v_i[PH_A]} + {1'b0, v_i[PH_C]};

    // Choose the voltage paired with the phase-B current
    always_comb begin : pick_b_voltage
        case (wire_mode_e'(mode_i))
            WM_AVG_B:   vb_eff = avg_ac[RMS_W:1];
            WM_SHARE_A: vb_eff = v_i[PH_A];
            default:    vb_eff = v_i[PH_B];
        endcase
    end

    assign v_eff[PH_A] = v_i[PH_A];
    assign v_eff[PH_B] = vb_eff;
    assign v_eff[PH_C] = v_i[PH_C];

    for (genvar k = 0; k < N_PH; k++) begin : g_prod
        assign prod[k] = sel_i[k] ? (PROD_W'(v_eff[k]) * PROD_W'(i_i[k])) : '0;
    end

    assign sum_o = SUM_W'(prod[PH_A]) + SUM_W'(prod[PH_B]) + SUM_W'(prod[PH_C]);
endmodule

// File: rtl/ae_pq_sum.sv
// Module: per-sample signed power sum and active-power magnitude sum.
// lin_o carries active (swap low) or reactive (swap high) of enabled phases;
// mag_o carries the sum of |active| of enabled phases. Inputs are two's complement.
module ae_pq_sum
    import ae_pkg::*;
#(
    parameter int PWR_W = 12,
    localparam int SUM_W = PWR_W + 2
) (
    input  logic [N_PH-1:0]             sel_i,
    input  logic                        swap_i,
    input  logic [N_PH-1:0][PWR_W-1:0]  p_i,
    input  logic [N_PH-1:0][PWR_W-1:0]  q_i,
    output logic [SUM_W-1:0]            lin_o,
    output logic [SUM_W-1:0]            mag_o
);
    logic [PWR_W-1:0] lin_t [N_PH];
    logic [PWR_W-1:0] mag_t [N_PH];
    logic [SUM_W-1:0] lin_x [N_PH];

    for (genvar k = 0; k < N_PH; k++) begin : g_ph
        logic [PWR_W-1:0] pk_neg;
        assign pk_neg   = -p_i[k];
        assign lin_t[k] = sel_i[k] ? (swap_i ? q_i[k] : p_i[k]) : '0;
        assign mag_t[k] = sel_i[k] ? (p_i[k][PWR_W-1] ? pk_neg : p_i[k]) : '0;
        assign lin_x[k] = {{2{lin_t[k][PWR_W-1]}}, lin_t[k]};
    end

    assign lin_o = lin_x[PH_A] + lin_x[PH_B] + lin_x[PH_C];
    assign mag_o = {2'b00, mag_t[PH_A]} + {2'b00, mag_t[PH_B]} + {2'b00, mag_t[PH_C]};
endmodule

// File: rtl/ae_window.sv
// Module: half-cycle window counter.
// Counts ticks; asserts close_o on the tick completing count_i ticks.
// count_i = 0 suspends and holds the count cleared. count_i assumed stable
// within a window.
module ae_window #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             close_o,
    output logic             idle_o
);
    logic [CNT_W-1:0] cnt_q;

    assign idle_o  = (count_i == '0);
    assign close_o = tick_i && !idle_o &&
                     (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, count_i});

    // Tick counter for the current window
    always_ff @(posedge clk) begin : cnt_reg
        if (!rst_n)       cnt_q <= '0;
        else if (idle_o)  cnt_q <= '0;
        else if (close_o) cnt_q <= '0;
        else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i != '0 && $stable(count_i)) |-> (cnt_q < count_i));

    assert_idle_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/ae_line_accum.sv
// Module: one line-cycle energy accumulator and its readable register.
// Adds term_i on add_i; on close_i latches total (incl. same-cycle term)
// and restarts from zero; idle_i holds the running total cleared.
module ae_line_accum #(
    parameter int IN_W   = 18,
    parameter int ACC_W  = 32,
    parameter bit SIGNED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_i,
    input  logic [IN_W-1:0]  term_i,
    input  logic             close_i,
    input  logic             idle_i,
    output logic [ACC_W-1:0] energy_o
);
    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;

    if (SIGNED) begin : g_sext
        assign ext = {{(ACC_W-IN_W){term_i[IN_W-1]}}, term_i};
    end else begin : g_zext
        assign ext = {{(ACC_W-IN_W){1'b0}}, term_i};
    end

    assign acc_nx = add_i ? (acc_q + ext) : acc_q;

    // Running total within the window
    always_ff @(posedge clk) begin : acc_reg
        if (!rst_n)                acc_q <= '0;
        else if (idle_i || close_i) acc_q <= '0;
        else                       acc_q <= acc_nx;
    end

    // Readable window total
    always_ff @(posedge clk) begin : out_reg
        if (!rst_n)       energy_o <= '0;
        else if (close_i) energy_o <= acc_nx;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !close_i |=> $stable(energy_o));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |=> (acc_q == '0));

    assert_idle_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (acc_q == '0));
endmodule

// File: rtl/lc_energy_acc.sv
// Module: three-phase line-cycle energy accumulator (top).
// Forms per-sample apparent, active and reactive terms and accumulates them
// over hc_count_i half-cycle ticks into two readable registers.
// Assumes configuration inputs change only at window boundaries.
module lc_energy_acc
    import ae_pkg::*;
#(
    parameter int RMS_W = 8,
    parameter int PWR_W = 12,
    parameter int CNT_W = 6,
    parameter int ACC_W = 32,
    localparam int VA_W  = 2 * RMS_W + 2,
    localparam int PQ_W  = PWR_W + 2,
    localparam int B_W   = (VA_W > PQ_W) ? VA_W : PQ_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_vld_i,
    input  logic                        hc_tick_i,
    input  logic [1:0]                  wire_mode_i,
    input  logic [2:0]                  va_sel_i,
    input  logic [2:0]                  pq_sel_i,
    input  logic                        swap_en_i,
    input  logic [CNT_W-1:0]            hc_count_i,
    input  logic [2:0][RMS_W-1:0]       v_rms_i,
    input  logic [2:0][RMS_W-1:0]       i_rms_i,
    input  logic [2:0][PWR_W-1:0]       p_i,
    input  logic [2:0][PWR_W-1:0]       q_i,
    output logic [ACC_W-1:0]            line_act_o,
    output logic [ACC_W-1:0]            line_va_o,
    output logic                        upd_o
);
    logic [VA_W-1:0] va_sum;
    logic [PQ_W-1:0] lin_sum;
    logic [PQ_W-1:0] mag_sum;
    logic [PQ_W-1:0] lin_abs;
    logic [B_W-1:0]  b_term;
    logic            close;
    logic            idle;

    ae_va_sum #(.RMS_W(RMS_W)) u_va (
        .mode_i (wire_mode_i),
        .sel_i  (va_sel_i),
        .v_i    (v_rms_i),
        .i_i    (i_rms_i),
        .sum_o  (va_sum)
    );

    ae_pq_sum #(.PWR_W(PWR_W)) u_pq (
        .sel_i  (pq_sel_i),
        .swap_i (swap_en_i),
        .p_i    (p_i),
        .q_i    (q_i),
        .lin_o  (lin_sum),
        .mag_o  (mag_sum)
    );

    ae_window #(.CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (hc_tick_i),
        .count_i (hc_count_i),
        .close_o (close),
        .idle_o  (idle)
    );

    // Unsigned register source: apparent normally, |active| when swapped
    assign b_term = swap_en_i ? B_W'(mag_sum) : B_W'(va_sum);

    ae_line_accum #(.IN_W(PQ_W), .ACC_W(ACC_W), .SIGNED(1'b1)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_i    (smp_vld_i && !idle),
        .term_i   (lin_sum),
        .close_i  (close),
        .idle_i   (idle),
        .energy_o (line_act_o)
    );

    ae_line_accum #(.IN_W(B_W), .ACC_W(ACC_W), .SIGNED(1'b0)) u_va_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_i    (smp_vld_i && !idle),
        .term_i   (b_term),
        .close_i  (close),
        .idle_i   (idle),
        .energy_o (line_va_o)
    );

    // Update flag, one cycle after the closing tick
    always_ff @(posedge clk) begin : upd_reg
        if (!rst_n) upd_o <= 1'b0;
        else        upd_o <= close;
    end

    assign lin_abs = lin_sum[PQ_W-1] ? (-lin_sum) : lin_sum;

    assert_mag_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_en_i && pq_sel_i == 3'b111) |-> (mag_sum >= lin_abs));

    assert_upd_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(hc_tick_i));

    assert_no_upd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_count_i == '0) |=> !upd_o);
endmodule

// File: tb/tb_lc_energy_acc.sv
// Scoreboard bench: driver model pushes expected window totals, monitor pops
// them on each update pulse and compares both registers.
module tb_lc_energy_acc;
    localparam int RMS_W = 8;
    localparam int PWR_W = 12;
    localparam int CNT_W = 6;
    localparam int ACC_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld, hc_tick, swap_en;
    logic [1:0] wire_mode;
    logic [2:0] va_sel, pq_sel;
    logic [CNT_W-1:0] hc_count;
    logic [2:0][RMS_W-1:0] v_rms, i_rms;
    logic [2:0][PWR_W-1:0] p, q;
    logic [ACC_W-1:0] line_act, line_va;
    logic upd;

    always #5 clk = ~clk;

    lc_energy_acc dut (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .hc_tick_i(hc_tick),
        .wire_mode_i(wire_mode), .va_sel_i(va_sel), .pq_sel_i(pq_sel),
        .swap_en_i(swap_en), .hc_count_i(hc_count), .v_rms_i(v_rms),
        .i_rms_i(i_rms), .p_i(p), .q_i(q), .line_act_o(line_act),
        .line_va_o(line_va), .upd_o(upd)
    );

    typedef struct {
        logic [ACC_W-1:0] act;
        logic [ACC_W-1:0] va;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R2";
    longint m_act = 0, m_va = 0;
    int m_cnt = 0;
    logic [ACC_W-1:0] last_act = '0, last_va = '0;

    function automatic longint sx(logic [PWR_W-1:0] x);
        return x[PWR_W-1] ? longint'(x) - (longint'(1) << PWR_W) : longint'(x);
    endfunction

    // Expected contribution of the current inputs, from the requirements
    function automatic void contrib(output longint a, output longint b);
        longint vb;
        a = 0; b = 0;
        for (int k = 0; k < 3; k++) begin
            if (pq_sel[k]) begin
                a += swap_en ? sx(q[k]) : sx(p[k]);
                if (swap_en) b += (sx(p[k]) < 0) ? -sx(p[k]) : sx(p[k]);
            end
        end
        if (!swap_en) begin
            case (wire_mode)
                2'd1:    vb = (longint'(v_rms[0]) + longint'(v_rms[2])) / 2;
                2'd2:    vb = longint'(v_rms[0]);
                default: vb = longint'(v_rms[1]);
            endcase
            if (va_sel[0]) b += longint'(v_rms[0]) * longint'(i_rms[0]);
            if (va_sel[1]) b += vb * longint'(i_rms[1]);
            if (va_sel[2]) b += longint'(v_rms[2]) * longint'(i_rms[2]);
        end
    endfunction

    task automatic step(input bit vld, input bit tck);
        longint a, b;
        exp_t e;
        @(negedge clk);
        smp_vld = vld;
        hc_tick = tck;
        for (int k = 0; k < 3; k++) begin
            v_rms[k] = RMS_W'($urandom);
            i_rms[k] = RMS_W'($urandom);
            p[k]     = PWR_W'($urandom);
            q[k]     = PWR_W'($urandom);
        end
        if (hc_count == '0) begin
            m_act = 0; m_va = 0; m_cnt = 0;
        end else begin
            if (vld) begin
                contrib(a, b);
                m_act += a;
                m_va  += b;
            end
            if (tck) begin
                if (m_cnt + 1 >= int'(hc_count)) begin
                    e.act = ACC_W'(m_act);
                    e.va  = ACC_W'(m_va);
                    e.tag = cur_tag;
                    exp_q.push_back(e);
                    last_act = e.act;
                    last_va  = e.va;
                    m_act = 0; m_va = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
    endtask

    // One full window: per half cycle some samples, then the tick
    task automatic window(input string tag, input int per_half, input bit vld_on_tick,
                          input bit sparse);
        cur_tag = tag;
        for (int h = 0; h < int'(hc_count); h++) begin
            for (int s = 0; s < per_half; s++) step(sparse ? bit'($urandom_range(0, 1)) : 1'b1, 1'b0);
            step(vld_on_tick, 1'b1);
        end
        step(1'b0, 1'b0);
    endtask

    task automatic check(input string tag, input logic [ACC_W-1:0] act,
                         input logic [ACC_W-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp_v);
        end
    endtask

    // Monitor: compare each update against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && upd) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R7/R10: unexpected update act=%0h va=%0h expected none",
                         line_act, line_va);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " line_act"}, line_act, e.act);
                check({e.tag, " line_va"},  line_va,  e.va);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        smp_vld = 0; hc_tick = 0; swap_en = 0; wire_mode = 0;
        va_sel = 3'b111; pq_sel = 3'b111; hc_count = 6'd2;
        v_rms = '0; i_rms = '0; p = '0; q = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 line_act", line_act, '0);
        check("R1 line_va", line_va, '0);
        check("R1 upd", ACC_W'(upd), '0);

        window("R2/R8 mode0", 3, 1'b1, 1'b0);
        wire_mode = 2'd1; window("R3 mode1", 2, 1'b1, 1'b0);
        wire_mode = 2'd2; window("R4 mode2", 2, 1'b1, 1'b0);
        wire_mode = 2'd3; window("R5 mode3", 2, 1'b1, 1'b0);
        wire_mode = 2'd0; va_sel = 3'b010; pq_sel = 3'b100;
        window("R6/R8 sel B", 2, 1'b1, 1'b0);
        wire_mode = 2'd1; va_sel = 3'b101; pq_sel = 3'b011;
        window("R6 sel AC", 2, 1'b0, 1'b0);
        va_sel = 3'b111; pq_sel = 3'b111; hc_count = 6'd1;
        window("R7 one half", 3, 1'b1, 1'b0);
        hc_count = 6'd3;
        window("R7 three halves", 2, 1'b1, 1'b0);
        hc_count = 6'd2;
        window("R11 sparse valid", 5, 1'b0, 1'b1);
        swap_en = 1'b1; pq_sel = 3'b011;
        window("R9 swap", 3, 1'b1, 1'b0);
        wire_mode = 2'd2; va_sel = 3'b000; pq_sel = 3'b111;
        window("R9 swap ignores mode", 2, 1'b1, 1'b0);
        swap_en = 1'b0; wire_mode = 2'd0; va_sel = 3'b111;
        window("R7 back", 2, 1'b1, 1'b0);

        // R10: suspended windows, registers must hold
        hc_count = '0;
        for (int t = 0; t < 6; t++) step(1'b1, t[0]);
        step(1'b0, 1'b0);
        @(negedge clk);
        check("R10 hold act", line_act, last_act);
        check("R10 hold va", line_va, last_va);
        hc_count = 6'd2;
        window("R10 resume fresh", 2, 1'b1, 1'b0);

        repeat (4) @(negedge clk);
        check("R7 queue drained", ACC_W'(exp_q.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule